// File: doc/BRIEF.md
# Three-Channel Single-Item DMA Engine

This block moves one data item per request between an internal RAM and a peripheral register space. It has three channels, and each one holds a source address, a destination address, a direction, an item width (8 or 16 bits) and a remaining-transfer count. A channel is set up in one cycle by pulsing its load strobe while the configuration inputs carry the new settings. After that, each pulse on its request input asks for exactly one item to be moved.

Before it takes the bus, the engine raises a bus request and waits for the CPU to grant it. The CPU grants the bus only when its current operation has finished. Every transfer then occupies the bus for four clocks: one clock on the RAM port and three clocks on the peripheral port, in the order the direction requires. After each transfer the bus goes back to the CPU for at least one cycle. This happens even when other channels are waiting.

Channels are served in fixed priority, lowest index first. When a channel's count runs out, it emits a one-cycle end-of-transfer interrupt and goes dormant until it is loaded again. The memory ports are plain strobed ports with no back-pressure: RAM read data is taken at the end of its single clock, and peripheral read data at the end of the third peripheral clock. Streaming handshakes are not used, because every transfer has a fixed length.

Top module: `sxd_top`

## Requirements
- R1: After reset, busy_o, bus_req_o, ram_en_o, per_en_o and done_irq_o are all 0, and every channel is unloaded (count 0).
- R2: A request pulse of a single cycle is held pending until its channel's transfer starts. A request that arrives in the same cycle the channel's transfer is granted is kept, and it causes one more transfer.
- R3: A transfer starts only in the cycle after a cycle in which bus_req_o and bus_gnt_i are both 1. While bus_gnt_i is 0, busy_o stays 0 and bus_req_o stays 1.
- R4: Each transfer holds busy_o high for exactly four consecutive cycles.
- R5: With cfg_to_ram_i = 0 (RAM to peripheral), the RAM is read at the source address in transfer clock 1. The peripheral is then written at the destination address with that data in clocks 2 to 4.
- R6: With cfg_to_ram_i = 1 (peripheral to RAM), the peripheral is read at the source address in clocks 1 to 3, and the RAM is written at the destination address in clock 4. RAM and peripheral are never enabled in the same cycle.
- R7: With cfg_half_i = 1 the item is 16 bits and xfer_hw_o is 1. With cfg_half_i = 0 only bits [7:0] are moved, the upper byte of the write data is 0, and xfer_hw_o is 0.
- R8: After every completed transfer, the channel's source and destination addresses each advance by 1 for byte items or by 2 for halfword items.
- R9: Channels whose requests are pending together are served in the order 0, 1, 2.
- R10: After every transfer there is at least one cycle in which busy_o and bus_req_o are both 0, so the CPU gets the bus back before any pending transfer starts.
- R11: When a channel finishes the transfer that brings its count to 0, its done_irq_o bit is high for exactly one cycle: the first cycle after busy_o falls. After that the channel ignores requests until it is loaded again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dreq_i | input | 3 | Per-channel transfer request pulses |
| bus_req_o | output | 1 | Engine asks the CPU for the bus |
| bus_gnt_i | input | 1 | CPU has finished its operation and yields the bus |
| cfg_load_i | input | 3 | Per-channel load strobe for the configuration inputs |
| cfg_src_i | input | 3x16 | Per-channel source address |
| cfg_dst_i | input | 3x16 | Per-channel destination address |
| cfg_to_ram_i | input | 3 | Direction: 1 = peripheral to RAM, 0 = RAM to peripheral |
| cfg_half_i | input | 3 | Item width: 1 = 16 bits, 0 = 8 bits |
| cfg_count_i | input | 3x16 | Number of transfers to perform |
| busy_o | output | 1 | Engine owns the bus (transfer in progress) |
| xfer_hw_o | output | 1 | Current transfer moves a 16-bit item |
| ram_en_o | output | 1 | RAM access strobe |
| ram_we_o | output | 1 | RAM write (1) or read (0) |
| ram_addr_o | output | 16 | RAM address |
| ram_wdata_o | output | 16 | RAM write data |
| ram_rdata_i | input | 16 | RAM read data, valid in the access cycle |
| per_en_o | output | 1 | Peripheral access strobe |
| per_we_o | output | 1 | Peripheral write (1) or read (0) |
| per_addr_o | output | 16 | Peripheral address |
| per_wdata_o | output | 16 | Peripheral write data |
| per_rdata_i | input | 16 | Peripheral read data, valid by the third access cycle |
| done_irq_o | output | 3 | Per-channel end-of-transfer interrupt pulse |

## Verification
Two functions can fall in the same cycle. One is a channel's pending bit being cleared because its transfer is granted. The other is a fresh request on that same channel. The bench provokes this by holding the request through the grant cycle, after first confirming that bus_req_o is high in that cycle. It judges the outcome by the scoreboard, which expects two complete transfers with consecutive addresses. A second overlap is three requests arriving together. There, the scoreboard order and the mandatory idle cycle after each transfer show that priority and the bus hand-back work together.

// File: rtl/sxd_pkg.sv
package sxd_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_XFER = 2'd1,
    S_GAP  = 2'd2
  } sxd_state_e;
endpackage

// File: rtl/sxd_chan.sv
module sxd_chan #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          load_i,
  input  logic [AW-1:0] cfg_src_i,
  input  logic [AW-1:0] cfg_dst_i,
  input  logic          cfg_to_ram_i,
  input  logic          cfg_half_i,
  input  logic [CW-1:0] cfg_count_i,
  input  logic          start_i,
  input  logic          done_i,
  output logic          pend_o,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic          to_ram_o,
  output logic          half_o,
  output logic          irq_o
);
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;
  logic          to_ram_q, half_q, pend_q, irq_q;
  logic          armed, last;
  logic [AW-1:0] step;

  assign armed = (cnt_q != '0);
  assign last  = done_i && (cnt_q == CW'(1));
  assign step  = half_q ? AW'(2) : AW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q    <= '0;
      dst_q    <= '0;
      cnt_q    <= '0;
      to_ram_q <= 1'b0;
      half_q   <= 1'b0;
      pend_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else if (load_i) begin
      src_q    <= cfg_src_i;
      dst_q    <= cfg_dst_i;
      cnt_q    <= cfg_count_i;
      to_ram_q <= cfg_to_ram_i;
      half_q   <= cfg_half_i;
      pend_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= last;
      if (done_i) begin
        src_q <= src_q + step;
        dst_q <= dst_q + step;
        cnt_q <= cnt_q - CW'(1);
      end
      // a fresh request wins over the clear at start (R2); final transfer drops all
      if (last) pend_q <= 1'b0;
      else      pend_q <= (req_i && armed) || (pend_q && !start_i);
    end
  end

  assign pend_o   = pend_q;
  assign src_o    = src_q;
  assign dst_o    = dst_q;
  assign to_ram_o = to_ram_q;
  assign half_o   = half_q;
  assign irq_o    = irq_q;

  a_r11_irq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);
  a_r11_dormant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed && !load_i) |=> !pend_q);
endmodule

// File: rtl/sxd_arb.sv
module sxd_arb #(
  parameter int NCH = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] pend_i,
  output logic [NCH-1:0] grant_o,
  output logic           any_o
);
  always_comb begin
    grant_o = '0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (pend_i[c]) grant_o = NCH'(1) << c;
    end
  end

  assign any_o = |pend_i;

  a_r9_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o) && (any_o == (grant_o != '0)));
endmodule

// File: rtl/sxd_seq.sv
module sxd_seq
  import sxd_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int PER_CLKS = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          to_ram_i,
  input  logic          half_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [DW-1:0] ram_rdata_i,
  input  logic [DW-1:0] per_rdata_i,
  output logic          idle_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          hw_o,
  output logic          ram_en_o,
  output logic          ram_we_o,
  output logic [AW-1:0] ram_addr_o,
  output logic [DW-1:0] ram_wdata_o,
  output logic          per_en_o,
  output logic          per_we_o,
  output logic [AW-1:0] per_addr_o,
  output logic [DW-1:0] per_wdata_o
);
  localparam int XFER_CLKS = PER_CLKS + 1;
  localparam int PW        = $clog2(XFER_CLKS);
  localparam int HB        = DW / 2;
  localparam logic [PW-1:0] LAST_PH = PW'(XFER_CLKS - 1);
  localparam logic [PW-1:0] RD_PH   = PW'(PER_CLKS - 1);

  sxd_state_e    st_q;
  logic [PW-1:0] ph_q;
  logic [DW-1:0] data_q;
  logic          xfer, ram_ph;

  function automatic logic [DW-1:0] shape(input logic hw, input logic [DW-1:0] d);
    shape = hw ? d : {{(DW - HB){1'b0}}, d[HB-1:0]};
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      ph_q   <= '0;
      data_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (start_i) begin
          st_q <= S_XFER;
          ph_q <= '0;
        end
        S_XFER: begin
          if (!to_ram_i && ph_q == '0)   data_q <= shape(half_i, ram_rdata_i);
          if (to_ram_i && ph_q == RD_PH) data_q <= shape(half_i, per_rdata_i);
          if (ph_q == LAST_PH) st_q <= S_GAP;
          else                 ph_q <= ph_q + 1'b1;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign xfer   = (st_q == S_XFER);
  assign ram_ph = to_ram_i ? (ph_q == LAST_PH) : (ph_q == '0);

  assign idle_o      = (st_q == S_IDLE);
  assign busy_o      = xfer;
  assign done_o      = xfer && (ph_q == LAST_PH);
  assign hw_o        = xfer && half_i;
  assign ram_en_o    = xfer && ram_ph;
  assign ram_we_o    = ram_en_o && to_ram_i;
  assign ram_addr_o  = to_ram_i ? dst_i : src_i;
  assign ram_wdata_o = data_q;
  assign per_en_o    = xfer && !ram_ph;
  assign per_we_o    = per_en_o && !to_ram_i;
  assign per_addr_o  = to_ram_i ? src_i : dst_i;
  assign per_wdata_o = data_q;

  a_r6_one_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ram_en_o && per_en_o));
  a_r6_ram_write_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |=> (st_q == S_GAP));
  a_r5_ram_read_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_en_o && !ram_we_o) |=> per_we_o);
endmodule

// File: rtl/sxd_top.sv
module sxd_top #(
  parameter int NCH      = 3,
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int CW       = 16,
  parameter int PER_CLKS = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NCH-1:0]          dreq_i,
  output logic                    bus_req_o,
  input  logic                    bus_gnt_i,
  input  logic [NCH-1:0]          cfg_load_i,
  input  logic [NCH-1:0][AW-1:0]  cfg_src_i,
  input  logic [NCH-1:0][AW-1:0]  cfg_dst_i,
  input  logic [NCH-1:0]          cfg_to_ram_i,
  input  logic [NCH-1:0]          cfg_half_i,
  input  logic [NCH-1:0][CW-1:0]  cfg_count_i,
  output logic                    busy_o,
  output logic                    xfer_hw_o,
  output logic                    ram_en_o,
  output logic                    ram_we_o,
  output logic [AW-1:0]           ram_addr_o,
  output logic [DW-1:0]           ram_wdata_o,
  input  logic [DW-1:0]           ram_rdata_i,
  output logic                    per_en_o,
  output logic                    per_we_o,
  output logic [AW-1:0]           per_addr_o,
  output logic [DW-1:0]           per_wdata_o,
  input  logic [DW-1:0]           per_rdata_i,
  output logic [NCH-1:0]          done_irq_o
);
  logic [NCH-1:0]         pend, grant, sel_q;
  logic [NCH-1:0][AW-1:0] ch_src, ch_dst;
  logic [NCH-1:0]         ch_to_ram, ch_half;
  logic                   any_pend, seq_idle, seq_done, start;
  logic [AW-1:0]          sel_src, sel_dst;
  logic                   sel_to_ram, sel_half;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    sxd_chan #(.AW(AW), .CW(CW)) chan_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .req_i       (dreq_i[g]),
      .load_i      (cfg_load_i[g]),
      .cfg_src_i   (cfg_src_i[g]),
      .cfg_dst_i   (cfg_dst_i[g]),
      .cfg_to_ram_i(cfg_to_ram_i[g]),
      .cfg_half_i  (cfg_half_i[g]),
      .cfg_count_i (cfg_count_i[g]),
      .start_i     (start && grant[g]),
      .done_i      (seq_done && sel_q[g]),
      .pend_o      (pend[g]),
      .src_o       (ch_src[g]),
      .dst_o       (ch_dst[g]),
      .to_ram_o    (ch_to_ram[g]),
      .half_o      (ch_half[g]),
      .irq_o       (done_irq_o[g])
    );
  end

  sxd_arb #(.NCH(NCH)) arb_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (pend),
    .grant_o(grant),
    .any_o  (any_pend)
  );

  assign bus_req_o = seq_idle && any_pend;
  assign start     = bus_req_o && bus_gnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sel_q <= '0;
    else if (start) sel_q <= grant;
  end

  always_comb begin
    sel_src    = '0;
    sel_dst    = '0;
    sel_to_ram = 1'b0;
    sel_half   = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      if (sel_q[c]) begin
        sel_src    = sel_src | ch_src[c];
        sel_dst    = sel_dst | ch_dst[c];
        sel_to_ram = sel_to_ram | ch_to_ram[c];
        sel_half   = sel_half | ch_half[c];
      end
    end
  end

  sxd_seq #(.AW(AW), .DW(DW), .PER_CLKS(PER_CLKS)) seq_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .to_ram_i   (sel_to_ram),
    .half_i     (sel_half),
    .src_i      (sel_src),
    .dst_i      (sel_dst),
    .ram_rdata_i(ram_rdata_i),
    .per_rdata_i(per_rdata_i),
    .idle_o     (seq_idle),
    .busy_o     (busy_o),
    .done_o     (seq_done),
    .hw_o       (xfer_hw_o),
    .ram_en_o   (ram_en_o),
    .ram_we_o   (ram_we_o),
    .ram_addr_o (ram_addr_o),
    .ram_wdata_o(ram_wdata_o),
    .per_en_o   (per_en_o),
    .per_we_o   (per_we_o),
    .per_addr_o (per_addr_o),
    .per_wdata_o(per_wdata_o)
  );

  a_r3_after_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(bus_req_o && bus_gnt_i));
  a_r10_hand_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !bus_req_o);
  a_r11_irq_in_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_irq_o != '0) |-> ($fell(busy_o) && $onehot(done_irq_o)));
endmodule

// File: tb/sxd_top_tb_top.sv
`timescale 1ns/1ps
module sxd_top_tb_top;
  typedef struct {
    bit          to_ram;
    bit          half;
    logic [15:0] raddr;
    logic [15:0] waddr;
    logic [15:0] data;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [2:0]       dreq = '0;
  logic             bus_req, bus_gnt, cpu_idle = 1'b1;
  logic [2:0]       cfg_load = '0;
  logic [2:0][15:0] cfg_src = '0, cfg_dst = '0, cfg_cnt = '0;
  logic [2:0]       cfg_to_ram = '0, cfg_half = '0;
  logic             busy, hw, ram_en, ram_we, per_en, per_we;
  logic [15:0]      ram_addr, ram_wdata, ram_rdata, per_addr, per_wdata, per_rdata;
  logic [2:0]       irq;

  function automatic logic [7:0] ram_b(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction
  function automatic logic [7:0] per_b(input logic [15:0] a);
    return a[7:0] + 8'h3C;
  endfunction

  assign ram_rdata = {ram_b(ram_addr + 16'd1), ram_b(ram_addr)};
  assign per_rdata = {per_b(per_addr + 16'd1), per_b(per_addr)};
  assign bus_gnt   = bus_req && cpu_idle;

  sxd_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .dreq_i(dreq), .bus_req_o(bus_req), .bus_gnt_i(bus_gnt),
    .cfg_load_i(cfg_load), .cfg_src_i(cfg_src), .cfg_dst_i(cfg_dst),
    .cfg_to_ram_i(cfg_to_ram), .cfg_half_i(cfg_half), .cfg_count_i(cfg_cnt),
    .busy_o(busy), .xfer_hw_o(hw), .ram_en_o(ram_en), .ram_we_o(ram_we),
    .ram_addr_o(ram_addr), .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata),
    .per_en_o(per_en), .per_we_o(per_we), .per_addr_o(per_addr),
    .per_wdata_o(per_wdata), .per_rdata_i(per_rdata), .done_irq_o(irq)
  );

  int n_chk = 0, n_fail = 0;
  bit ended = 0;
  exp_t q[$];
  logic [15:0] sh_src[3], sh_dst[3], sh_cnt[3];
  bit sh_to_ram[3], sh_half[3];
  int exp_irq[3], seen_irq[3];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic load_ch(input int c, input bit to_ram, input bit half,
                         input logic [15:0] s, input logic [15:0] d, input logic [15:0] n);
    @(negedge clk);
    cfg_src[c] = s; cfg_dst[c] = d; cfg_cnt[c] = n;
    cfg_to_ram[c] = to_ram; cfg_half[c] = half; cfg_load[c] = 1'b1;
    sh_src[c] = s; sh_dst[c] = d; sh_cnt[c] = n; sh_to_ram[c] = to_ram; sh_half[c] = half;
    @(negedge clk);
    cfg_load = '0;
  endtask

  // driver side of the scoreboard: predict one item from the shadow settings
  task automatic push_exp(input int c);
    exp_t e;
    logic [15:0] s;
    if (sh_cnt[c] == 16'd0) return;
    s = sh_src[c];
    e.to_ram = sh_to_ram[c];
    e.half   = sh_half[c];
    e.raddr  = s;
    e.waddr  = sh_dst[c];
    if (sh_to_ram[c]) e.data = sh_half[c] ? {per_b(s + 16'd1), per_b(s)} : {8'h00, per_b(s)};
    else              e.data = sh_half[c] ? {ram_b(s + 16'd1), ram_b(s)} : {8'h00, ram_b(s)};
    q.push_back(e);
    sh_src[c] = s + (sh_half[c] ? 16'd2 : 16'd1);
    sh_dst[c] = sh_dst[c] + (sh_half[c] ? 16'd2 : 16'd1);
    sh_cnt[c] = sh_cnt[c] - 16'd1;
    if (sh_cnt[c] == 16'd0) exp_irq[c]++;
  endtask

  task automatic pulse(input logic [2:0] m);
    @(negedge clk);
    dreq = m;
    @(negedge clk);
    dreq = '0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // monitor side of the scoreboard
  int pos = 0;
  bit prev_busy = 0;
  logic [15:0] rd_addr;
  bit rd_per;
  always @(negedge clk) begin
    if (rst_n && !ended) begin
      if (busy) begin
        pos = prev_busy ? pos + 1 : 0;
        if (pos == 0) begin
          rd_addr = ram_en ? ram_addr : per_addr;
          rd_per  = per_en;
        end
        if (pos == 1 || pos == 2)
          chk(per_en && !ram_en, "R5 R6 peripheral clocks 2-3", {per_en, ram_en}, 2'b10);
        if (pos == 3) begin
          if (q.size() == 0) begin
            chk(0, "R11 unexpected transfer", {ram_addr, per_addr}, 0);
          end else begin
            exp_t e;
            e = q.pop_front();
            if (e.to_ram) begin
              chk(ram_en && ram_we && !per_en, "R6 RAM write in clock 4", {ram_en, ram_we, per_en}, 3'b110);
              chk(ram_addr == e.waddr, "R8 RAM write address", ram_addr, e.waddr);
              chk(ram_wdata == e.data, "R7 RAM write data", ram_wdata, e.data);
              chk(rd_per, "R6 peripheral read first", rd_per, 1);
            end else begin
              chk(per_en && per_we && !ram_en, "R5 peripheral write held", {per_en, per_we, ram_en}, 3'b110);
              chk(per_addr == e.waddr, "R8 peripheral write address", per_addr, e.waddr);
              chk(per_wdata == e.data, "R7 peripheral write data", per_wdata, e.data);
              chk(!rd_per, "R5 RAM read in clock 1", rd_per, 0);
            end
            chk(rd_addr == e.raddr, "R8 read address", rd_addr, e.raddr);
            chk(hw == e.half, "R7 width flag", hw, e.half);
          end
        end
      end
      if (!busy && prev_busy) begin
        chk(pos == 3, "R4 four busy clocks", pos + 1, 4);
        chk(!bus_req, "R10 bus handed back", bus_req, 0);
      end
      for (int c = 0; c < 3; c++) begin
        if (irq[c]) begin
          seen_irq[c]++;
          chk(prev_busy && !busy, "R11 irq in first idle cycle", {prev_busy, busy}, 2'b10);
        end
      end
      prev_busy = busy;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    for (int c = 0; c < 3; c++) begin
      sh_cnt[c] = 0; exp_irq[c] = 0; seen_irq[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk({busy, bus_req, ram_en, per_en, irq} == 7'd0, "R1 reset outputs",
        {busy, bus_req, ram_en, per_en, irq}, 0);

    // R2: request held through the grant cycle gives two transfers
    load_ch(0, 1'b0, 1'b0, 16'h0020, 16'h0400, 16'd3);
    push_exp(0); push_exp(0);
    @(negedge clk); dreq = 3'b001;
    @(negedge clk);
    chk(bus_req && !busy, "R2 grant cycle reached", {bus_req, busy}, 2'b10);
    @(negedge clk); dreq = '0;
    drain();
    chk(q.size() == 0, "R2 both transfers done", q.size(), 0);
    push_exp(0);
    pulse(3'b001);
    drain();
    chk(seen_irq[0] == 1, "R11 ch0 terminal irq", seen_irq[0], 1);
    // R11: exhausted channel ignores requests
    pulse(3'b001);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(!bus_req && !busy, "R11 request ignored after count", {bus_req, busy}, 0);
    end

    // R3: CPU keeps the bus
    load_ch(1, 1'b1, 1'b1, 16'h0600, 16'h0080, 16'd2);
    cpu_idle = 1'b0;
    push_exp(1);
    pulse(3'b010);
    for (int i = 0; i < 6; i++) begin
      chk(bus_req && !busy, "R3 wait for grant", {bus_req, busy}, 2'b10);
      @(negedge clk);
    end
    cpu_idle = 1'b1;
    @(negedge clk);
    chk(busy, "R3 start after grant", busy, 1);
    drain();
    push_exp(1);
    pulse(3'b010);
    drain();
    chk(seen_irq[1] == 1, "R11 ch1 terminal irq", seen_irq[1], 1);

    // R9/R10: simultaneous requests
    load_ch(0, 1'b1, 1'b0, 16'h0700, 16'h00C0, 16'd2);
    load_ch(1, 1'b0, 1'b1, 16'h0030, 16'h0500, 16'd2);
    load_ch(2, 1'b0, 1'b1, 16'h0040, 16'h0520, 16'd1);
    push_exp(0); push_exp(1); push_exp(2);
    pulse(3'b111);
    drain();
    chk(q.size() == 0, "R9 three transfers in priority order", q.size(), 0);
    push_exp(0); push_exp(1);
    pulse(3'b011);
    drain();

    for (int c = 0; c < 3; c++)
      chk(seen_irq[c] == exp_irq[c], "R11 irq count", seen_irq[c], exp_irq[c]);
    chk(q.size() == 0, "R2 scoreboard empty", q.size(), 0);
    summary();
  end
endmodule